// File: doc/BRIEF.md
# External Bus Cycle Controller

This block runs one read or write cycle at a time on an external asynchronous memory bus on behalf of a processor core. The core places a request on a strobe-qualified interface: an address, a 24-bit write word and a read/write flag. The controller then drives the external address, the write data with its output enable, and active-low read or write strobes. It answers with a single-clock done pulse and, for reads, the captured data word. A decoder compares the top address bits against per-line base and mask settings and selects one chip-select line. Each line has its own active level.

A cycle lasts for a programmed minimum number of wait states. An external active-low acknowledge can stretch it without limit. The cycle ends one clock after the acknowledge is seen, or when the minimum expires, whichever is later. The acknowledge only matters when the programmed count is one or more. It is used directly in synchronous mode, or after a two-flop synchronizer in asynchronous mode. When the controller does not own the bus, its strobe, chip-select and data output enables are low and queued requests wait.

The state machine has two states. ST_IDLE moves to ST_ACCESS on START, which needs a queued request while the bus is owned. ST_ACCESS moves back to ST_IDLE on FINISH, which needs the wait counter at zero and the acknowledge condition met. ST_ACCESS otherwise holds on STRETCH.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: During and right after reset, ext_rd_n and ext_wr_n are 1, done is 0 and ext_data_oe is 0.
- R2: A read cycle pulls only ext_rd_n low and a write cycle pulls only ext_wr_n low. During a write, ext_data_oe is 1 and ext_data_o equals the requested write word.
- R3: With cfg_wait = 0 the strobe is low for exactly one clock, whatever the acknowledge does.
- R4: With cfg_wait = W of 1 or more, the strobe is low for at least W+1 clocks, and for exactly W+1 when the acknowledge arrives early.
- R5: In synchronous mode (cfg_ack_async = 0), the strobe returns high one clock after the first rising clock edge inside the cycle at which ext_ack_n is sampled 0. The strobe-low length is therefore max(W+1, D+2) when ext_ack_n falls during strobe-low clock D+1.
- R6: In asynchronous mode (cfg_ack_async = 1), the acknowledge passes two flops first. The length becomes max(W+1, D+4) for the same stimulus.
- R7: While bus_master = 0, ext_strobe_oe, ext_cs_oe and ext_data_oe are 0 and no cycle starts. A held request runs once bus_master returns to 1.
- R8: An acknowledge asserted while no cycle is in progress starts nothing and produces no done pulse.
- R9: Line i matches when ((addr[AW-1:AW-TW] ^ base_i) & mask_i) == 0, with line i occupying bits [i*TW +: TW] of cfg_cs_base and cfg_cs_mask. The lowest matching index is asserted, at level cfg_cs_pol[i] (1 = active high). No line is asserted outside cycles or when nothing matches, and the strobes still run in that case.
- R10: done is high for exactly one clock, at the edge that ends the cycle. rdata then holds ext_data_i as sampled on the last strobe-low clock.
- R11: A request taken while a cycle is running is held and starts after that cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-clock request strobe from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write word |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read word |
| bus_master | input | 1 | 1 while the controller owns the bus |
| cfg_wait | input | WW | Minimum wait states |
| cfg_ack_async | input | 1 | 1 = synchronize the acknowledge |
| cfg_cs_base | input | NCS*TW | Per-line base tags |
| cfg_cs_mask | input | NCS*TW | Per-line compare masks |
| cfg_cs_pol | input | NCS | Per-line active level |
| ext_addr | output | AW | External address |
| ext_data_o | output | DW | External data out |
| ext_data_i | input | DW | External data in |
| ext_data_oe | output | 1 | Data bus drive enable |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_strobe_oe | output | 1 | Strobe drive enable |
| ext_cs | output | NCS | Chip-select levels |
| ext_cs_oe | output | 1 | Chip-select drive enable |
| ext_ack_n | input | 1 | Active-low transfer acknowledge |

## Verification
The assertions assume that the cfg_* inputs stay constant during a cycle and that bus_master does not fall while a strobe is low. They also assume the core has at most one request waiting behind the running cycle, and that the acknowledge is released after each strobe rises. The stimulus changes configuration only after a done pulse has been seen. It raises or lowers bus_master only while the controller is idle. It issues a second request only during a cycle that has nothing queued behind it. Its memory model releases the acknowledge on the first falling edge after the strobe returns high.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } xbus_state_e;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/xbus_ack_sync.sv
module xbus_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_raw,
    input  logic use_sync,
    output logic ack_q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], ack_raw};
    end

    assign ack_q = use_sync ? pipe[STAGES-1] : ack_raw;
endmodule

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode #(
    parameter int NCS = 4,
    parameter int TW  = 4
) (
    input  logic [TW-1:0]     tag,
    input  logic [NCS*TW-1:0] base,
    input  logic [NCS*TW-1:0] mask,
    input  logic [NCS-1:0]    pol,
    input  logic              active,
    output logic [NCS-1:0]    cs_level
);
    logic [NCS-1:0] hit;
    logic [NCS-1:0] sel;

    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign hit[i] = ((tag ^ base[i*TW +: TW]) & mask[i*TW +: TW]) == '0;
    end

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NCS; i++) begin
            if (hit[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign cs_level = ~(pol ^ (sel & {NCS{active}}));
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl #(
    parameter int AW  = 16,
    parameter int DW  = 24,
    parameter int WW  = 4,
    parameter int NCS = 4,
    parameter int TW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              done,
    output logic [DW-1:0]     rdata,
    input  logic              bus_master,
    input  logic [WW-1:0]     cfg_wait,
    input  logic              cfg_ack_async,
    input  logic [NCS*TW-1:0] cfg_cs_base,
    input  logic [NCS*TW-1:0] cfg_cs_mask,
    input  logic [NCS-1:0]    cfg_cs_pol,
    output logic [AW-1:0]     ext_addr,
    output logic [DW-1:0]     ext_data_o,
    input  logic [DW-1:0]     ext_data_i,
    output logic              ext_data_oe,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_strobe_oe,
    output logic [NCS-1:0]    ext_cs,
    output logic              ext_cs_oe,
    input  logic              ext_ack_n
);
    import xbus_pkg::*;

    localparam int SYNC = SYNC_STAGES;
    localparam int BLW  = $clog2(SYNC + 1);

    xbus_state_e state_q, state_d;

    logic          pend_valid, pend_write;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_wdata;
    logic          cyc_write;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_wdata;
    logic [WW-1:0] wait_cnt;
    logic [BLW-1:0] blank_cnt;
    logic          ack_en, ack_hit, ack_in;
    logic          done_q;
    logic [DW-1:0] rdata_q;
    logic          start, finish, in_acc;

    xbus_ack_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_raw  (~ext_ack_n),
        .use_sync (cfg_ack_async),
        .ack_q    (ack_in)
    );

    xbus_cs_decode #(.NCS(NCS), .TW(TW)) u_cs_decode (
        .tag      (cyc_addr[AW-1 -: TW]),
        .base     (cfg_cs_base),
        .mask     (cfg_cs_mask),
        .pol      (cfg_cs_pol),
        .active   (in_acc),
        .cs_level (ext_cs)
    );

    assign in_acc = (state_q == ST_ACCESS);
    assign start  = (state_q == ST_IDLE) && pend_valid && bus_master;
    assign finish = in_acc && (wait_cnt == '0) && (!ack_en || ack_hit);

    // Next state: START, FINISH, STRETCH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)  state_d = ST_ACCESS;
            ST_ACCESS: if (finish) state_d = ST_IDLE;
        endcase
    end

    // State register and cycle datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_valid <= 1'b0;
            pend_write <= 1'b0;
            pend_addr  <= '0;
            pend_wdata <= '0;
            cyc_write  <= 1'b0;
            cyc_addr   <= '0;
            cyc_wdata  <= '0;
            wait_cnt   <= '0;
            blank_cnt  <= '0;
            ack_en     <= 1'b0;
            ack_hit    <= 1'b0;
            done_q     <= 1'b0;
            rdata_q    <= '0;
        end else begin
            state_q    <= state_d;
            pend_valid <= (pend_valid && !start) || req_valid;
            if (req_valid) begin
                pend_write <= req_write;
                pend_addr  <= req_addr;
                pend_wdata <= req_wdata;
            end
            if (start) begin
                cyc_write <= pend_write;
                cyc_addr  <= pend_addr;
                cyc_wdata <= pend_wdata;
                wait_cnt  <= cfg_wait;
                ack_en    <= (cfg_wait != '0);
                ack_hit   <= 1'b0;
                blank_cnt <= cfg_ack_async ? BLW'(SYNC) : '0;
            end else if (in_acc) begin
                if (wait_cnt != '0)  wait_cnt  <= wait_cnt - 1'b1;
                if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
                else if (ack_in)     ack_hit   <= 1'b1;
            end
            done_q <= finish;
            if (finish && !cyc_write) rdata_q <= ext_data_i;
        end
    end

    // Outputs
    always_comb begin
        ext_rd_n      = !(in_acc && !cyc_write && bus_master);
        ext_wr_n      = !(in_acc &&  cyc_write && bus_master);
        ext_data_oe   = in_acc && cyc_write && bus_master;
        ext_strobe_oe = bus_master;
        ext_cs_oe     = bus_master;
        ext_addr      = cyc_addr;
        ext_data_o    = cyc_wdata;
        done          = done_q;
        rdata         = rdata_q;
    end
endmodule

// File: rtl/xbus_cycle_ctrl_chk.sv
module xbus_cycle_ctrl_chk #(
    parameter int WW  = 4,
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ext_rd_n,
    input logic           ext_wr_n,
    input logic           ext_data_oe,
    input logic           done,
    input logic [WW-1:0]  cfg_wait,
    input logic [NCS-1:0] ext_cs,
    input logic [NCS-1:0] cfg_cs_pol
);
    logic        strobe_low;
    logic [15:0] low_cnt;
    logic [NCS-1:0] cs_act;

    assign strobe_low = !ext_rd_n || !ext_wr_n;
    assign cs_act     = ~(ext_cs ^ cfg_cs_pol);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              low_cnt <= '0;
        else if (!strobe_low)                    low_cnt <= '0;
        else if (low_cnt != 16'hFFFF)            low_cnt <= low_cnt + 16'd1;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n)); // R2
    AST_DATA_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        ext_data_oe |-> !ext_wr_n); // R2
    AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_low && low_cnt == 16'd0 && cfg_wait == '0) |=> !strobe_low); // R3
    AST_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_low && low_cnt != 16'd0) |-> (low_cnt >= 16'(cfg_wait) + 16'd1)); // R4
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_act)); // R9
    AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_low |-> (cs_act == '0)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

bind xbus_cycle_ctrl xbus_cycle_ctrl_chk #(.WW(WW), .NCS(NCS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n),
    .ext_data_oe (ext_data_oe),
    .done        (done),
    .cfg_wait    (cfg_wait),
    .ext_cs      (ext_cs),
    .cfg_cs_pol  (cfg_cs_pol)
);

// File: tb/xbus_cycle_ctrl_tb.sv
module xbus_cycle_ctrl_tb;
    localparam int AW = 16, DW = 24, WW = 4, NCS = 4, TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic done;
    logic [DW-1:0] rdata;
    logic bus_master = 1'b1;
    logic [WW-1:0] cfg_wait = '0;
    logic cfg_ack_async = 1'b0;
    logic [NCS*TW-1:0] cfg_cs_base = {4'hC, 4'h4, 4'h4, 4'h0};
    logic [NCS*TW-1:0] cfg_cs_mask = {4'hC, 4'hC, 4'hF, 4'hC};
    logic [NCS-1:0] cfg_cs_pol = 4'b0101;
    logic [AW-1:0] ext_addr;
    logic [DW-1:0] ext_data_o;
    logic [DW-1:0] ext_data_i = '0;
    logic ext_data_oe, ext_rd_n, ext_wr_n, ext_strobe_oe, ext_cs_oe;
    logic [NCS-1:0] ext_cs;
    logic ext_ack_n = 1'b1;

    xbus_cycle_ctrl #(.AW(AW), .DW(DW), .WW(WW), .NCS(NCS), .TW(TW)) u_dut (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    int k = 0, last_len = 0, mem_delay = 0, done_cnt = 0;
    bit force_idle_ack = 1'b0, seen_rd = 1'b0, seen_wr = 1'b0;
    logic [DW-1:0] mem_rdata = '0, seen_wdata = '0;
    logic [NCS-1:0] seen_cs = '0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(int w, bit async_m, int d);
        int a;
        if (w == 0) return 1;
        a = d + (async_m ? 4 : 2);
        return (w + 1 > a) ? w + 1 : a;
    endfunction

    function automatic logic [NCS-1:0] exp_cs(logic [AW-1:0] a);
        logic [NCS-1:0] v;
        bit found;
        v = ~cfg_cs_pol;
        found = 1'b0;
        for (int i = 0; i < NCS; i++) begin
            if (!found && (((a[AW-1 -: TW] ^ cfg_cs_base[i*TW +: TW]) & cfg_cs_mask[i*TW +: TW]) == '0)) begin
                v[i] = cfg_cs_pol[i];
                found = 1'b1;
            end
        end
        return v;
    endfunction

    // Memory model: acknowledge after mem_delay strobe-low clocks
    always @(negedge clk) begin
        if (done) done_cnt++;
        if ((!ext_rd_n || !ext_wr_n) && ext_strobe_oe) begin
            k++;
            if (k == 1) begin seen_rd = 1'b0; seen_wr = 1'b0; end
            seen_rd |= !ext_rd_n;
            seen_wr |= !ext_wr_n;
            if (ext_data_oe) seen_wdata = ext_data_o;
            seen_cs = ext_cs;
            ext_ack_n = (k >= mem_delay + 1) ? 1'b0 : 1'b1;
        end else begin
            if (k != 0) last_len = k;
            k = 0;
            ext_ack_n = force_idle_ack ? 1'b0 : 1'b1;
        end
        ext_data_i = mem_rdata;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic issue(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(int target);
        int t = 0;
        while (done_cnt < target && t < 300) begin @(negedge clk); t++; end
        check(done_cnt >= target, "R10 done timeout", done_cnt, target);
    endtask

    task automatic run_cycle(bit w, logic [AW-1:0] a, logic [DW-1:0] d, int wt, bit am, int dl);
        int d0, e;
        string lbl;
        cfg_wait = WW'(wt); cfg_ack_async = am; mem_delay = dl;
        mem_rdata = DW'($urandom);
        d0 = done_cnt;
        issue(w, a, d);
        wait_done(d0 + 1);
        @(negedge clk);
        check(done == 1'b0 && done_cnt == d0 + 1, "R10 done one clock", done_cnt, d0 + 1);
        @(negedge clk);
        e = exp_len(wt, am, dl);
        lbl = (wt == 0) ? "R3 zero-wait length" : (e == wt + 1) ? "R4 minimum length" :
              am ? "R6 async stretch length" : "R5 sync stretch length";
        check(last_len == e, lbl, last_len, e);
        if (w) begin
            check(seen_wr && !seen_rd, "R2 write strobe", {seen_rd, seen_wr}, 2'b01);
            check(seen_wdata == d, "R2 write data", seen_wdata, d);
        end else begin
            check(seen_rd && !seen_wr, "R2 read strobe", {seen_rd, seen_wr}, 2'b10);
            check(rdata == mem_rdata, "R10 read data", rdata, mem_rdata);
        end
        check(seen_cs == exp_cs(a), "R9 chip select", seen_cs, exp_cs(a));
    endtask

    initial begin
        int r, d0;
        r = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ext_rd_n && ext_wr_n && !done && !ext_data_oe, "R1 reset",
              {ext_rd_n, ext_wr_n, done, ext_data_oe}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        check(ext_rd_n && ext_wr_n && !done && !ext_data_oe, "R1 after reset",
              {ext_rd_n, ext_wr_n, done, ext_data_oe}, 4'b1100);

        // Directed corner cases
        run_cycle(0, 16'h0123, 24'h0, 0, 0, 5);   // R3 ack ignored
        run_cycle(1, 16'h4567, 24'hABCDEF, 0, 1, 5); // R3
        run_cycle(0, 16'h5000, 24'h0, 1, 0, 0);   // R4
        run_cycle(1, 16'hC001, 24'h123456, 3, 0, 0); // R4
        run_cycle(0, 16'h4000, 24'h0, 3, 0, 5);   // R5
        run_cycle(0, 16'h0FFF, 24'h0, 1, 1, 0);   // R6
        run_cycle(1, 16'h7777, 24'h777777, 3, 1, 0); // R6
        run_cycle(0, 16'h1234, 24'h0, 1, 0, 20);  // R5 long stretch
        run_cycle(1, 16'h9ABC, 24'h0F0F0F, 1, 0, 0); // R9 no match, strobe runs

        // R8: acknowledge while idle
        force_idle_ack = 1'b1; cfg_wait = 4'd1; cfg_ack_async = 1'b0;
        d0 = done_cnt;
        repeat (10) @(negedge clk);
        check(done_cnt == d0 && ext_rd_n && ext_wr_n, "R8 idle ack ignored", done_cnt, d0);
        force_idle_ack = 1'b0;
        repeat (2) @(negedge clk);

        // R7: not bus master
        bus_master = 1'b0; mem_rdata = 24'h5A5A5A; mem_delay = 0;
        d0 = done_cnt;
        issue(0, 16'h0042, 24'h0);
        repeat (8) @(negedge clk);
        check(!ext_strobe_oe && !ext_cs_oe && !ext_data_oe, "R7 enables off",
              {ext_strobe_oe, ext_cs_oe, ext_data_oe}, 3'b000);
        check(done_cnt == d0, "R7 no cycle", done_cnt, d0);
        bus_master = 1'b1;
        wait_done(d0 + 1);
        @(negedge clk);
        check(rdata == 24'h5A5A5A, "R7 held request runs", rdata, 24'h5A5A5A);

        // R11: request while busy
        cfg_wait = 4'd3; cfg_ack_async = 1'b0; mem_delay = 0;
        d0 = done_cnt;
        issue(1, 16'h0100, 24'h111111);
        issue(1, 16'h0200, 24'h222222);
        wait_done(d0 + 2);
        repeat (2) @(negedge clk);
        check(done_cnt == d0 + 2, "R11 two cycles", done_cnt, d0 + 2);
        check(seen_wdata == 24'h222222, "R11 second data", seen_wdata, 24'h222222);
        check(last_len == 4, "R11 second length", last_len, 4);

        // Constrained random
        for (int i = 0; i < 40; i++) begin
            int sel, wt;
            sel = $urandom % 4;
            wt = (sel == 0) ? 0 : (sel == 1) ? 1 : (sel == 2) ? 3 : int'($urandom % 6);
            run_cycle(1'($urandom % 2), AW'($urandom), DW'($urandom), wt,
                      1'($urandom % 2), int'($urandom % 7));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule